// File: doc/BRIEF.md
# Multi-Size Address Translation Buffer

This block caches virtual-to-physical address translations in 32 fully associative slots. Each slot records its own region size: 4 KiB, 64 KiB or 1 MiB. The size decides how many upper virtual address bits the slot compares. The low bits below that boundary pass through untranslated into the physical address.

A combinational lookup port returns a hit flag, the translated physical address and the slot's attribute bits, all computed from the registered slots. An external table walker loads translations through a refill port. The slot it writes is picked by a round-robin pointer, which advances on refills only.

A maintenance port clears the whole buffer, or clears every slot whose region covers a given virtual address. Permission checks, domains, faults and walking are handled elsewhere.

Top module: `multisize_tlb`

## Requirements
- R1: After reset every slot is invalid, so any lookup reports `lookupHit` = 0 with `lookupPa` = 0 and `lookupAttr` = 0.
- R2: `refillSize` code 0 selects a 4 KiB page that compares virtual bits [31:12]. Code 1 selects a 64 KiB page that compares bits [31:16]. Code 2 selects a 1 MiB region that compares bits [31:20]. Code 3 behaves as code 0.
- R3: On a hit, `lookupPa` takes its bits above the size boundary from `refillPa` of the winning slot and its bits below the boundary from `lookupVa`, and `lookupAttr` is that slot's `refillAttr`. On a miss, both outputs are 0.
- R4: A translation loaded by a refill at one clock edge is visible to a combinational lookup in the cycle that follows that edge.
- R5: When several valid slots match one lookup address, the lowest-numbered slot supplies the result.
- R6: A refill writes the slot named by a round-robin pointer. The pointer is 0 after reset, advances by one on each refill and wraps from 31 to 0, so the 33rd refill overwrites the first slot loaded.
- R7: Lookups and both kinds of flush leave the round-robin pointer where it is.
- R8: `flushAllEn` invalidates every slot. A refill in the same cycle still leaves its new slot valid.
- R9: `flushOneEn` invalidates every valid slot whose region (judged by that slot's own size) contains `flushVa`, and leaves all other slots intact. A refill in the same cycle still leaves its new slot valid, even when that slot matches `flushVa`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| lookupVa | input | 32 | Virtual address to translate |
| lookupHit | output | 1 | A valid slot covers lookupVa |
| lookupPa | output | 32 | Translated physical address, 0 on a miss |
| lookupAttr | output | ATTR_W (8) | Attribute bits of the winning slot, 0 on a miss |
| refillEn | input | 1 | Load a translation into the pointer's slot |
| refillVa | input | 32 | Virtual address of the new translation |
| refillPa | input | 32 | Physical base of the new translation |
| refillSize | input | 2 | Region size code (0 = 4 KiB, 1 = 64 KiB, 2 = 1 MiB, 3 = 4 KiB) |
| refillAttr | input | ATTR_W (8) | Attribute bits stored with the translation |
| flushAllEn | input | 1 | Invalidate every slot |
| flushOneEn | input | 1 | Invalidate slots covering flushVa |
| flushVa | input | 32 | Address for the selective flush |

## Verification
A refill and a flush can land in the same cycle. In that cycle the flush acts on the slots that were already present, while the refill's new slot must survive.

The bench provokes both pairings with directed cases. One case pairs a refill with a whole-buffer flush. The other pairs a refill with a selective flush of the very address being loaded. The randomized phase also issues refills, flushes and lookups with overlapping probabilities over a small address pool, so collisions recur many times.

Each cycle's lookup is judged against a bench model that applies the flush to the old contents first and then writes the new slot. Any ordering error shows up as a wrong hit flag or a stale physical address.

// File: rtl/multisize_tlb_pkg.sv
package multisize_tlb_pkg;

  localparam int VA_W        = 32;
  localparam int SMALL_SHIFT = 12;
  localparam int LARGE_SHIFT = 16;
  localparam int SEG_SHIFT   = 20;
  localparam int PN_W        = VA_W - SMALL_SHIFT;

  typedef enum logic [1:0] {
    SZ_SMALL = 2'd0,
    SZ_LARGE = 2'd1,
    SZ_SEG   = 2'd2,
    SZ_ALT   = 2'd3
  } regionSize_e;

  typedef struct packed {
    logic writeEn;
    logic clearAll;
    logic clearMatch;
  } tlbStrobes_t;

  // Page-number bits that take part in the tag compare for a given size.
  function automatic logic [PN_W-1:0] pageMask(regionSize_e sz);
    logic [PN_W-1:0] m;
    case (sz)
      SZ_SEG:   m = {PN_W{1'b1}} << (SEG_SHIFT - SMALL_SHIFT);
      SZ_LARGE: m = {PN_W{1'b1}} << (LARGE_SHIFT - SMALL_SHIFT);
      default:  m = {PN_W{1'b1}};
    endcase
    return m;
  endfunction

  function automatic logic regionHit(logic [PN_W-1:0] tagPn, regionSize_e sz,
                                     logic [PN_W-1:0] probePn);
    return ((tagPn ^ probePn) & pageMask(sz)) == '0;
  endfunction

  function automatic logic [VA_W-1:0] composePa(logic [PN_W-1:0] frame, regionSize_e sz,
                                                logic [VA_W-1:0] va);
    logic [PN_W-1:0] m;
    m = pageMask(sz);
    return {(frame & m) | (va[VA_W-1:SMALL_SHIFT] & ~m), va[SMALL_SHIFT-1:0]};
  endfunction

endpackage

// File: rtl/multisize_tlb_ctrl.sv
module multisize_tlb_ctrl
  import multisize_tlb_pkg::*;
#(
  parameter int NUM_ENTRIES = 32,
  parameter int IDX_W       = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             refillEn,
  input  logic             flushAllEn,
  input  logic             flushOneEn,
  output tlbStrobes_t      strobes,
  output logic [IDX_W-1:0] victimIdx
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ENTRIES - 1);

  logic [IDX_W-1:0] rrPtr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rrPtr <= '0;
    end else if (refillEn) begin
      rrPtr <= (rrPtr == LAST_IDX) ? '0 : rrPtr + 1'b1;
    end
  end

  always_comb begin
    strobes.writeEn    = refillEn;
    strobes.clearAll   = flushAllEn;
    strobes.clearMatch = flushOneEn;
  end

  assign victimIdx = rrPtr;

endmodule

// File: rtl/multisize_tlb_array.sv
module multisize_tlb_array
  import multisize_tlb_pkg::*;
#(
  parameter int NUM_ENTRIES = 32,
  parameter int ATTR_W      = 8,
  parameter int IDX_W       = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  tlbStrobes_t       strobes,
  input  logic [IDX_W-1:0]  victimIdx,
  input  logic [PN_W-1:0]   refillVpn,
  input  logic [PN_W-1:0]   refillFrame,
  input  regionSize_e       refillSize,
  input  logic [ATTR_W-1:0] refillAttr,
  input  logic [PN_W-1:0]   flushVpn,
  input  logic [VA_W-1:0]   lookupVa,
  output logic              lookupHit,
  output logic [VA_W-1:0]   lookupPa,
  output logic [ATTR_W-1:0] lookupAttr
);

  logic              validQ [NUM_ENTRIES];
  logic [PN_W-1:0]   vpnQ   [NUM_ENTRIES];
  logic [PN_W-1:0]   frameQ [NUM_ENTRIES];
  regionSize_e       sizeQ  [NUM_ENTRIES];
  logic [ATTR_W-1:0] attrQ  [NUM_ENTRIES];

  logic [NUM_ENTRIES-1:0] lookupMatch;
  logic [NUM_ENTRIES-1:0] flushMatch;

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_entry
    logic selWrite;
    assign selWrite = strobes.writeEn && (victimIdx == IDX_W'(e));

    assign lookupMatch[e] = validQ[e] &&
                            regionHit(vpnQ[e], sizeQ[e], lookupVa[VA_W-1:SMALL_SHIFT]);
    assign flushMatch[e]  = validQ[e] && regionHit(vpnQ[e], sizeQ[e], flushVpn);

    // The refill write outranks either flush on its own slot.
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        validQ[e] <= 1'b0;
      end else if (selWrite) begin
        validQ[e] <= 1'b1;
      end else if (strobes.clearAll || (strobes.clearMatch && flushMatch[e])) begin
        validQ[e] <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (selWrite) begin
        vpnQ[e]   <= refillVpn;
        frameQ[e] <= refillFrame;
        sizeQ[e]  <= refillSize;
        attrQ[e]  <= refillAttr;
      end
    end
  end

  // Lowest-numbered match wins: scan from the top so lower slots overwrite.
  logic [IDX_W-1:0] hitIdx;
  logic             anyHit;

  always_comb begin
    hitIdx = '0;
    anyHit = 1'b0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (lookupMatch[i]) begin
        anyHit = 1'b1;
        hitIdx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    lookupHit  = anyHit;
    lookupPa   = '0;
    lookupAttr = '0;
    if (anyHit) begin
      lookupPa   = composePa(frameQ[hitIdx], sizeQ[hitIdx], lookupVa);
      lookupAttr = attrQ[hitIdx];
    end
  end

endmodule

// File: rtl/multisize_tlb.sv
module multisize_tlb
  import multisize_tlb_pkg::*;
#(
  parameter int NUM_ENTRIES = 32,
  parameter int ATTR_W      = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [31:0]       lookupVa,
  output logic              lookupHit,
  output logic [31:0]       lookupPa,
  output logic [ATTR_W-1:0] lookupAttr,
  input  logic              refillEn,
  input  logic [31:0]       refillVa,
  input  logic [31:0]       refillPa,
  input  logic [1:0]        refillSize,
  input  logic [ATTR_W-1:0] refillAttr,
  input  logic              flushAllEn,
  input  logic              flushOneEn,
  input  logic [31:0]       flushVa
);

  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;

  tlbStrobes_t      strobes;
  logic [IDX_W-1:0] victimIdx;

  logic unusedLowBits;
  assign unusedLowBits = ^{refillVa[SMALL_SHIFT-1:0], refillPa[SMALL_SHIFT-1:0],
                           flushVa[SMALL_SHIFT-1:0]};

  multisize_tlb_ctrl #(
    .NUM_ENTRIES(NUM_ENTRIES),
    .IDX_W      (IDX_W)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .refillEn  (refillEn),
    .flushAllEn(flushAllEn),
    .flushOneEn(flushOneEn),
    .strobes   (strobes),
    .victimIdx (victimIdx)
  );

  multisize_tlb_array #(
    .NUM_ENTRIES(NUM_ENTRIES),
    .ATTR_W     (ATTR_W),
    .IDX_W      (IDX_W)
  ) u_array (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .victimIdx  (victimIdx),
    .refillVpn  (refillVa[VA_W-1:SMALL_SHIFT]),
    .refillFrame(refillPa[VA_W-1:SMALL_SHIFT]),
    .refillSize (regionSize_e'(refillSize)),
    .refillAttr (refillAttr),
    .flushVpn   (flushVa[VA_W-1:SMALL_SHIFT]),
    .lookupVa   (lookupVa),
    .lookupHit  (lookupHit),
    .lookupPa   (lookupPa),
    .lookupAttr (lookupAttr)
  );

endmodule

// File: rtl/multisize_tlb_checker.sv
module multisize_tlb_checker #(
  parameter int NUM_ENTRIES = 32,
  parameter int IDX_W       = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic [31:0]      lookupVa,
  input logic             lookupHit,
  input logic [31:0]      lookupPa,
  input logic             refillEn,
  input logic [31:0]      refillVa,
  input logic             flushAllEn,
  input logic             flushOneEn,
  input logic [31:0]      flushVa,
  input logic [IDX_W-1:0] victimIdx
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ENTRIES - 1);

  assert_low_offset_R3: assert property (@(posedge clk) disable iff (!rstN)
    lookupHit |-> lookupPa[11:0] == lookupVa[11:0]);

  assert_refill_visible_R4: assert property (@(posedge clk) disable iff (!rstN)
    refillEn |=> (lookupVa != $past(refillVa)) || lookupHit);

  assert_ptr_step_R6: assert property (@(posedge clk) disable iff (!rstN)
    refillEn |=> victimIdx == (($past(victimIdx) == LAST_IDX) ? '0 : $past(victimIdx) + 1'b1));

  assert_ptr_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !refillEn |=> $stable(victimIdx));

  assert_flush_all_R8: assert property (@(posedge clk) disable iff (!rstN)
    (flushAllEn && !refillEn) |=> !lookupHit);

  assert_flush_one_R9: assert property (@(posedge clk) disable iff (!rstN)
    (flushOneEn && !refillEn) |=> (lookupVa != $past(flushVa)) || !lookupHit);

endmodule

bind multisize_tlb multisize_tlb_checker #(
  .NUM_ENTRIES(NUM_ENTRIES),
  .IDX_W      (IDX_W)
) u_checker (
  .clk       (clk),
  .rstN      (rstN),
  .lookupVa  (lookupVa),
  .lookupHit (lookupHit),
  .lookupPa  (lookupPa),
  .refillEn  (refillEn),
  .refillVa  (refillVa),
  .flushAllEn(flushAllEn),
  .flushOneEn(flushOneEn),
  .flushVa   (flushVa),
  .victimIdx (victimIdx)
);

// File: tb/tb_multisize_tlb.sv
`timescale 1ns/1ps
module tb_multisize_tlb;

  localparam int N  = 32;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [31:0]   lookupVa = '0;
  logic          lookupHit;
  logic [31:0]   lookupPa;
  logic [AW-1:0] lookupAttr;
  logic          refillEn = 1'b0;
  logic [31:0]   refillVa = '0;
  logic [31:0]   refillPa = '0;
  logic [1:0]    refillSize = '0;
  logic [AW-1:0] refillAttr = '0;
  logic          flushAllEn = 1'b0;
  logic          flushOneEn = 1'b0;
  logic [31:0]   flushVa = '0;

  always #2 clk = ~clk;

  multisize_tlb #(.NUM_ENTRIES(N), .ATTR_W(AW)) dut (
    .clk(clk), .rstN(rstN), .lookupVa(lookupVa), .lookupHit(lookupHit),
    .lookupPa(lookupPa), .lookupAttr(lookupAttr), .refillEn(refillEn),
    .refillVa(refillVa), .refillPa(refillPa), .refillSize(refillSize),
    .refillAttr(refillAttr), .flushAllEn(flushAllEn), .flushOneEn(flushOneEn),
    .flushVa(flushVa)
  );

  int testCount = 0;
  int failCount = 0;
  bit done = 1'b0;

  // Reference model built from the requirements.
  bit          mValid [N];
  bit [31:0]   mVa    [N];
  bit [31:0]   mPa    [N];
  bit [1:0]    mSize  [N];
  bit [AW-1:0] mAttr  [N];
  int          mPtr;

  function automatic int sizeShift(bit [1:0] sz);
    if (sz == 2'd2) return 20;
    if (sz == 2'd1) return 16;
    return 12;
  endfunction

  function automatic bit covers(int i, bit [31:0] va);
    int sh;
    sh = sizeShift(mSize[i]);
    return mValid[i] && ((mVa[i] >> sh) == (va >> sh));
  endfunction

  task automatic modelReset();
    for (int i = 0; i < N; i++) mValid[i] = 1'b0;
    mPtr = 0;
  endtask

  task automatic checkLookup(string tag);
    bit          eHit;
    bit [31:0]   ePa;
    bit [AW-1:0] eAttr;
    eHit = 1'b0; ePa = '0; eAttr = '0;
    for (int i = 0; i < N; i++) begin
      if (!eHit && covers(i, lookupVa)) begin
        bit [31:0] low;
        eHit  = 1'b1;
        low   = (32'd1 << sizeShift(mSize[i])) - 32'd1;
        ePa   = (mPa[i] & ~low) | (lookupVa & low);
        eAttr = mAttr[i];
      end
    end
    testCount++;
    if (lookupHit !== eHit || lookupPa !== ePa || lookupAttr !== eAttr) begin
      failCount++;
      $display("FAIL %s va=%h: hit=%0b pa=%h attr=%h expected hit=%0b pa=%h attr=%h",
               tag, lookupVa, lookupHit, lookupPa, lookupAttr, eHit, ePa, eAttr);
    end
  endtask

  // One cycle: drive inputs after the falling edge, check the lookup,
  // apply the model (flush on old contents, then refill), then step.
  task automatic cycle(string tag, bit [31:0] lva,
                       bit rEn = 0, bit [31:0] rVa = 0, bit [31:0] rPa = 0,
                       bit [1:0] rSz = 0, bit [AW-1:0] rAt = 0,
                       bit fa = 0, bit fo = 0, bit [31:0] fVa = 0);
    lookupVa = lva; refillEn = rEn; refillVa = rVa; refillPa = rPa;
    refillSize = rSz; refillAttr = rAt; flushAllEn = fa; flushOneEn = fo; flushVa = fVa;
    #1;
    checkLookup(tag);
    if (fa) begin
      for (int i = 0; i < N; i++) mValid[i] = 1'b0;
    end else if (fo) begin
      bit hitMask [N];
      for (int i = 0; i < N; i++) hitMask[i] = covers(i, fVa);
      for (int i = 0; i < N; i++) if (hitMask[i]) mValid[i] = 1'b0;
    end
    if (rEn) begin
      mValid[mPtr] = 1'b1; mVa[mPtr] = rVa; mPa[mPtr] = rPa;
      mSize[mPtr] = rSz; mAttr[mPtr] = rAt;
      mPtr = (mPtr + 1) % N;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic applyReset();
    @(negedge clk);
    rstN = 1'b0;
    refillEn = 0; flushAllEn = 0; flushOneEn = 0;
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  function automatic bit [31:0] randVa();
    bit [31:0] v;
    v = $urandom;
    v[31:29] = '0;
    v[28] = $urandom_range(0, 1);
    v[27:22] = '0;
    v[19:18] = '0;
    v[15:14] = '0;
    return v;
  endfunction

  initial begin
    #(4 * 150000);
    if (!done) begin
      failCount++;
      $display("FAIL watchdog expired: run did not complete");
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    applyReset();

    // R1: reset state
    cycle("R1 reset miss", 32'h1234_5678);
    cycle("R1 reset miss 0", 32'h0000_0000);

    // R2 R3 R4: each size, hit next cycle after the refill
    cycle("R2 load seg", 32'h0, 1, 32'hABC0_0000, 32'h1230_0000, 2'd2, 8'h11);
    cycle("R4 R3 seg hit", 32'hABC1_2345);
    cycle("R2 seg miss", 32'hABD1_2345);
    cycle("R2 load large", 32'h0, 1, 32'h5555_0000, 32'h7777_0000, 2'd1, 8'h22);
    cycle("R3 large hit", 32'h5555_ABCD);
    cycle("R2 large miss", 32'h5556_ABCD);
    cycle("R2 load small", 32'h0, 1, 32'h0000_1000, 32'h0000_A000, 2'd0, 8'h33);
    cycle("R3 small hit", 32'h0000_1FFF);
    cycle("R2 small miss", 32'h0000_2000);
    cycle("R2 load code3", 32'h0, 1, 32'h0000_3000, 32'h0000_B000, 2'd3, 8'h44);
    cycle("R2 code3 hit", 32'h0000_3004);
    cycle("R2 code3 miss", 32'h0000_4004);

    // R5: overlapping slots, lower index wins
    cycle("R5 load seg", 32'h0, 1, 32'h6000_0000, 32'h1000_0000, 2'd2, 8'h55);
    cycle("R5 load large", 32'h0, 1, 32'h6001_0000, 32'h2000_0000, 2'd1, 8'h66);
    cycle("R5 lowest wins", 32'h6001_0004);

    // R9: selective flush with a same-cycle refill of the flushed address
    cycle("R9 flush+refill", 32'h6000_0000, 1, 32'h6000_0000, 32'h3000_0000, 2'd0, 8'h77,
          0, 1, 32'h6000_0000);
    cycle("R9 new slot survives", 32'h6000_0000);
    cycle("R9 other slot kept", 32'h6001_0004);
    cycle("R9 untouched seg", 32'hABC0_0010);

    // R8: whole flush with a same-cycle refill
    cycle("R8 flush+refill", 32'h0, 1, 32'h7000_0000, 32'h4000_0000, 2'd0, 8'h88, 1);
    cycle("R8 old gone", 32'hABC1_2345);
    cycle("R8 new kept", 32'h7000_0123);
    cycle("R8 flush alone", 32'h0, 0, 0, 0, 0, 0, 1);
    cycle("R8 all gone", 32'h7000_0123);

    // R6 R7: flushes and lookups do not move the pointer; wrap evicts slot 0
    applyReset();
    cycle("R6 load first", 32'h0, 1, 32'h0F00_0000, 32'h0010_0000, 2'd0, 8'h99);
    for (int k = 0; k < 4; k++)
      cycle("R7 flush unrelated", 32'h0F00_0000, 0, 0, 0, 0, 0, 0, 1, 32'h0E00_0000);
    for (int k = 0; k < 31; k++)
      cycle("R7 filler", 32'h0F00_0000, 1, 32'h2000_0000 + (k << 12), 32'h0300_0000 + (k << 12),
            2'd0, 8'(k));
    cycle("R7 first still held", 32'h0F00_0004);
    cycle("R6 wrap refill", 32'h0F00_0000, 1, 32'h2100_0000, 32'h0400_0000, 2'd0, 8'hA0);
    cycle("R6 first evicted", 32'h0F00_0004);
    cycle("R6 wrap slot loaded", 32'h2100_0004);

    // Random mix over a small address pool (all requirements, R5 overlaps)
    for (int k = 0; k < 3000; k++) begin
      bit [31:0] rv;
      bit [31:0] lv;
      int pick;
      rv = randVa();
      pick = $urandom_range(0, 99);
      lv = (pick < 30) ? rv : randVa();
      cycle("R2/R3/R5/R6/R9 random", lv,
            ($urandom_range(0, 99) < 40), rv, $urandom, 2'($urandom_range(0, 3)), 8'($urandom),
            ($urandom_range(0, 99) < 2), ($urandom_range(0, 99) < 12), randVa());
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule